// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Readout

This block is the digital half of a 16-bit successive-approximation converter. A host asserts an active-low chip select together with a combined read/convert line. When both are low and the block is idle, a conversion begins. The block searches for the code one bit per clock, starting at the most significant bit, and a single comparator bit decides whether each trial bit stays set. At the end it stores the code in two's complement in a result register. It holds an active-low busy flag low for the whole conversion and releases it one cycle after the register update.

The result reaches the host on a 16-bit output bus that is split into two byte halves. Each half has its own enable, so a pad ring or a shared bus can tri-state it. A byte-select pin swaps the halves, so an 8-bit host reads both bytes over one half. The same read/convert line also serves as an abort: a falling edge while busy is low ends the conversion. After an abort, the line must stay high for a full acquisition period before another start is taken. If the start condition is still present when busy rises, the block begins again at once and flags that result as invalid. All control and status pins are plain level signals, with no handshake.

Top module: `sar_conv_if`

## Requirements
- R1: While idle with busy_n high, busy_n goes low at the next clock edge once cs_n and rdconv are both low, whichever of them fell last; with only one of them low, busy_n stays high.
- R2: The search tests result bits from bit 15 down to bit 0, one per clock cycle; cmp_in = 1 in a decision cycle keeps the trial bit, 0 clears it; the result register is written at the edge that takes the 16th decision.
- R3: The stored code is two's complement: the search code with bit 15 inverted, so all-ones decisions give 0x7FFF, all-zeros give 0x8000, a decision pattern of 0x8000 gives 0x0000 and 0x7FFF gives 0xFFFF.
- R4: busy_n stays low for exactly 17 cycles (16 decisions plus one) and rises one cycle after the result register is written; the result never changes while busy_n is high.
- R5: Both bits of bus_oe are 1 exactly when cs_n is 0 and rdconv is 1; in every other combination bus_oe is 2'b00.
- R6: With byte_sel = 0, bus_data[15:8] carries result bits 15..8 and bus_data[7:0] carries bits 7..0; with byte_sel = 1 the two halves are exchanged.
- R7: For the first PREV_HOLD (default 4) cycles after a start, bus_data still shows the previous result.
- R8: A falling edge of rdconv while busy_n is low aborts the conversion: busy_n is high after that edge and the result register keeps its old value.
- R9: After an abort, no start is accepted until rdconv has been high for ACQ_CYC (default 8) consecutive cycles; a low cycle in between restarts the count.
- R10: If cs_n and rdconv are both low at the edge where busy_n rises, a new conversion starts on the next edge and its result sets result_bad to 1; a conversion started normally clears result_bad to 0.
- R11: After reset busy_n is 1, result is 0x0000 and result_bad is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rdconv | input | 1 | Low: convert request; high: read; falling edge while busy aborts |
| byte_sel | input | 1 | Exchanges the two byte halves on the bus |
| cmp_in | input | 1 | Comparator decision for the current trial bit |
| busy_n | output | 1 | Low while a conversion is in progress |
| result | output | 16 | Last completed two's-complement code |
| result_bad | output | 1 | Last result came from a conversion without fresh acquisition |
| bus_data | output | 16 | Output bus data, byte-ordered per byte_sel |
| bus_oe | output | 2 | Per-half drive enable, bit 1 upper half, bit 0 lower half |

## Verification
Busy falls one edge after the start condition is sampled. The comparator bit for result bit 15-k must be presented after edge k and is consumed at edge k+1. The result is due after edge 16, and busy rises after edge 17. An abort takes effect at the edge that sees rdconv low after a high cycle. The bus enables and the byte swap are combinational. The bench therefore drives all inputs one time unit after a rising edge, then samples registered outputs straight after the next edge plus that offset, and it settles bus values one more unit after changing byte_sel, cs_n or rdconv.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_FIN   = 2'd2,
    ST_RECOV = 2'd3
  } conv_state_e;

  // Strobes from the sequencer to the search datapath
  typedef struct packed {
    logic start;   // load first trial code
    logic step;    // take one comparator decision
    logic stale;   // conversion began without acquisition
  } search_ctl_t;

endpackage

// File: rtl/sar_seq_ctl.sv
module sar_seq_ctl
  import sar_if_pkg::*;
#(
  parameter int ACQ_CYC   = 8,
  parameter int PREV_HOLD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rdconv,
  input  logic        last_bit,
  output search_ctl_t ctl,
  output logic        busy_n,
  output logic        live_sel
);

  localparam int ACQ_W = (ACQ_CYC > 1) ? $clog2(ACQ_CYC) : 1;
  localparam int WIN_W = $clog2(PREV_HOLD + 1) > 0 ? $clog2(PREV_HOLD + 1) : 1;
  localparam logic [ACQ_W-1:0] ACQ_LAST = ACQ_W'(ACQ_CYC - 1);
  localparam logic [WIN_W-1:0] WIN_END  = WIN_W'(PREV_HOLD);

  conv_state_e state_q, state_d;
  logic [ACQ_W-1:0] acq_q;
  logic [WIN_W-1:0] win_q;
  logic rc_q;
  logic stale_arm_q;
  logic start_req, rc_fall, start, abort;

  assign start_req = ~cs_n & ~rdconv;
  assign rc_fall   = rc_q & ~rdconv;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    abort   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_CONV;
          start   = 1'b1;
        end
      end
      ST_CONV: begin
        if (rc_fall) begin
          state_d = ST_RECOV;
          abort   = 1'b1;
        end else if (last_bit) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN:   state_d = ST_IDLE;
      ST_RECOV: begin
        if (rdconv && (acq_q == ACQ_LAST)) state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      acq_q       <= '0;
      win_q       <= '0;
      rc_q        <= 1'b1;
      stale_arm_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rc_q        <= rdconv;
      stale_arm_q <= (state_q == ST_FIN) && start_req;
      if (state_q != ST_RECOV || !rdconv) acq_q <= '0;
      else                                acq_q <= acq_q + 1'b1;
      if (start)                               win_q <= '0;
      else if (!busy_n && win_q != WIN_END)    win_q <= win_q + 1'b1;
    end
  end

  assign busy_n    = (state_q == ST_IDLE) || (state_q == ST_RECOV);
  assign live_sel  = !busy_n && (win_q == WIN_END);
  assign ctl.start = start;
  assign ctl.step  = (state_q == ST_CONV) && !abort;
  assign ctl.stale = stale_arm_q;

  // R1: an accepted start drops busy on the following edge
  a_r1_start_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cs_n && !rdconv) |=> !busy_n);

  // R4: a busy rise that ends a conversion follows the finishing cycle
  a_r4_rise_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_n) && state_q == ST_IDLE) |-> ($past(state_q) == ST_FIN));

  // R8: falling read/convert during a conversion releases busy at once
  a_r8_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && rc_q && !rdconv) |=> (busy_n && state_q == ST_RECOV));

  // R9: while recovering, a low read/convert never starts a conversion
  a_r9_recovery_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV && !rdconv) |=> busy_n);

endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_if_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  search_ctl_t      ctl,
  input  logic             cmp_in,
  output logic             last_bit,
  output logic [NBITS-1:0] work_code,
  output logic [NBITS-1:0] result,
  output logic             result_bad
);

  localparam int IDX_W = $clog2(NBITS);
  localparam logic [NBITS-1:0] FIRST_TRIAL = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(NBITS - 1);

  logic [NBITS-1:0] sar_q, nxt, res_q;
  logic [IDX_W-1:0] idx_q;
  logic bad_q, stale_q;

  // Resolve the current trial bit and raise the next one
  always_comb begin
    nxt        = sar_q;
    nxt[idx_q] = cmp_in;
    if (idx_q != '0) nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q   <= '0;
      idx_q   <= '0;
      res_q   <= '0;
      bad_q   <= 1'b0;
      stale_q <= 1'b0;
    end else if (ctl.start) begin
      sar_q   <= FIRST_TRIAL;
      idx_q   <= TOP_IDX;
      stale_q <= ctl.stale;
    end else if (ctl.step) begin
      sar_q <= nxt;
      idx_q <= idx_q - 1'b1;
      if (idx_q == '0) begin
        res_q <= {~nxt[NBITS-1], nxt[NBITS-2:0]};
        bad_q <= stale_q;
      end
    end
  end

  assign last_bit   = (idx_q == '0);
  assign work_code  = sar_q;
  assign result     = res_q;
  assign result_bad = bad_q;

  // R10: the final decision of a no-acquisition conversion raises the flag
  a_r10_stale_marks_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && last_bit && stale_q) |=> result_bad);

endmodule

// File: rtl/sar_bus_drv.sv
module sar_bus_drv #(
  parameter int NBITS = 16
) (
  input  logic             cs_n,
  input  logic             rdconv,
  input  logic             byte_sel,
  input  logic             live_sel,
  input  logic [NBITS-1:0] held,
  input  logic [NBITS-1:0] live,
  output logic [NBITS-1:0] bus_data,
  output logic [1:0]       bus_oe
);

  localparam int HALF = NBITS / 2;

  logic [NBITS-1:0] src;
  logic             rd_en;

  assign src   = live_sel ? live : held;
  assign rd_en = ~cs_n & rdconv;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign bus_oe[h] = rd_en;
    assign bus_data[h*HALF +: HALF] = byte_sel ? src[(1-h)*HALF +: HALF]
                                               : src[h*HALF +: HALF];
  end

endmodule

// File: rtl/sar_conv_if.sv
module sar_conv_if
  import sar_if_pkg::*;
#(
  parameter int NBITS     = 16,
  parameter int ACQ_CYC   = 8,
  parameter int PREV_HOLD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rdconv,
  input  logic             byte_sel,
  input  logic             cmp_in,
  output logic             busy_n,
  output logic [NBITS-1:0] result,
  output logic             result_bad,
  output logic [NBITS-1:0] bus_data,
  output logic [1:0]       bus_oe
);

  search_ctl_t      ctl;
  logic             last_bit, live_sel;
  logic [NBITS-1:0] work_code;

  sar_seq_ctl #(.ACQ_CYC(ACQ_CYC), .PREV_HOLD(PREV_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdconv(rdconv),
    .last_bit(last_bit), .ctl(ctl), .busy_n(busy_n), .live_sel(live_sel)
  );

  sar_search #(.NBITS(NBITS)) u_search (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cmp_in(cmp_in),
    .last_bit(last_bit), .work_code(work_code),
    .result(result), .result_bad(result_bad)
  );

  sar_bus_drv #(.NBITS(NBITS)) u_bus (
    .cs_n(cs_n), .rdconv(rdconv), .byte_sel(byte_sel), .live_sel(live_sel),
    .held(result), .live(work_code), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  // R4: the result register only moves while busy is low
  a_r4_result_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> !busy_n);

endmodule

// File: tb/sar_conv_if_test.sv
`timescale 1ns/1ps
module sar_conv_if_test;

  localparam int ACQ = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, rdconv, byte_sel, cmp_in;
  logic busy_n, result_bad;
  logic [15:0] result, bus_data;
  logic [1:0] bus_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] last_res = 16'h0000;

  always #2.5 clk = ~clk;

  sar_conv_if uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdconv(rdconv),
    .byte_sel(byte_sel), .cmp_in(cmp_in), .busy_n(busy_n),
    .result(result), .result_bad(result_bad),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );

  // {comparator decision pattern, expected two's-complement code}
  localparam logic [31:0] VEC [6] = '{
    {16'hFFFF, 16'h7FFF},
    {16'h0000, 16'h8000},
    {16'h8000, 16'h0000},
    {16'h7FFF, 16'hFFFF},
    {16'hA5C3, 16'h25C3},
    {16'h1234, 16'h9234}
  };

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // One conversion; decisions follow pattern u, MSB first
  task automatic do_conv(input logic [15:0] u, input logic [15:0] exp,
                         input bit hold, input bit exp_bad);
    cs_n = 1'b0; rdconv = 1'b0; byte_sel = 1'b0; cmp_in = u[15];
    tick;
    chk("R1 busy low after start", {15'd0, busy_n}, 16'd0);
    if (!hold) begin
      rdconv = 1'b1;
      #1;
      chk("R7 previous result at start", bus_data, last_res);
      chk("R5 enables while reading", {14'd0, bus_oe}, 16'd3);
    end
    for (int k = 1; k < 16; k++) begin
      tick;
      if (!hold && k == 3) chk("R7 previous result in window", bus_data, last_res);
      cmp_in = u[15-k];
    end
    tick;
    chk("R2 R3 stored code", result, exp);
    chk("R4 busy low at update", {15'd0, busy_n}, 16'd0);
    chk("R10 invalid flag", {15'd0, result_bad}, {15'd0, exp_bad});
    tick;
    chk("R4 busy high after update", {15'd0, busy_n}, 16'd1);
    last_res = exp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      summary;
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rdconv = 1'b1; byte_sel = 1'b0; cmp_in = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    // R11 reset state
    chk("R11 busy after reset", {15'd0, busy_n}, 16'd1);
    chk("R11 result after reset", result, 16'h0000);
    chk("R11 flag after reset", {15'd0, result_bad}, 16'd0);
    chk("R5 no enable with cs high", {14'd0, bus_oe}, 16'd0);

    // R5 enable combinations
    cs_n = 1'b0; rdconv = 1'b1; #1;
    chk("R5 enable cs low read high", {14'd0, bus_oe}, 16'd3);
    cs_n = 1'b1; rdconv = 1'b0; #1;
    chk("R5 no enable cs high read low", {14'd0, bus_oe}, 16'd0);
    tick;
    chk("R1 no start with cs high", {15'd0, busy_n}, 16'd1);
    tick;
    chk("R1 still idle with cs high", {15'd0, busy_n}, 16'd1);

    // R1 chip select falls last, then R8 abort
    cs_n = 1'b0;
    tick;
    chk("R1 start by chip select", {15'd0, busy_n}, 16'd0);
    rdconv = 1'b1;
    tick;
    chk("R8 still busy before abort", {15'd0, busy_n}, 16'd0);
    rdconv = 1'b0;
    tick;
    chk("R8 busy released by abort", {15'd0, busy_n}, 16'd1);
    chk("R8 result kept", result, last_res);

    // R9 recovery needs a full high period
    tick;
    chk("R9 no start right after abort", {15'd0, busy_n}, 16'd1);
    tick;
    chk("R9 no start while low", {15'd0, busy_n}, 16'd1);
    rdconv = 1'b1;
    repeat (ACQ - 1) tick;
    rdconv = 1'b0;
    tick;
    chk("R9 short high period rejected", {15'd0, busy_n}, 16'd1);
    chk("R8 result kept after recovery", result, last_res);
    rdconv = 1'b1;
    repeat (ACQ) tick;
    chk("R9 idle after full period", {15'd0, busy_n}, 16'd1);

    // Vector table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < 6; i++) begin
      do_conv(VEC[i][31:16], VEC[i][15:0], 1'b0, 1'b0);
      cs_n = 1'b0; rdconv = 1'b1; byte_sel = 1'b0; #1;
      chk("R6 straight byte order", bus_data, VEC[i][15:0]);
      byte_sel = 1'b1; #1;
      chk("R6 swapped byte order", bus_data, {VEC[i][7:0], VEC[i][15:8]});
      byte_sel = 1'b0; cs_n = 1'b1; #1;
      chk("R5 enables drop with cs high", {14'd0, bus_oe}, 16'd0);
      tick;
    end

    // R10 back-to-back start marks the result invalid, a normal one clears it
    do_conv(16'h4321, 16'hC321, 1'b1, 1'b0);
    do_conv(16'hF00F, 16'h700F, 1'b0, 1'b1);
    do_conv(16'h0F0F, 16'h8F0F, 1'b0, 1'b0);

    done = 1'b1;
    summary;
    $finish;
  end

endmodule